// File: doc/BRIEF.md
# Dual-Direction Latched/Registered Bus Transceiver

This block moves 18-bit words, without inversion, between two bus ports, A and B, in both directions at once. Each direction owns one storage cell. When that direction's latch enable is high, the cell is transparent and follows the source port. When the latch enable is low, the cell is loaded only on a falling edge of that direction's capture clock. When the latch enable itself falls, the cell keeps the word that was present just before the edge. Each direction has its own drive enable. The A-to-B enable is active high and the B-to-A enable is active low.

Tri-state pads are modelled as three vectors per port: the value seen on the wire, a per-bit flag that says whether an outside driver is present, and the value and drive enable that the block puts out. A bus-hold stage on each port keeps the last driven level of any bit that is left floating.

All control inputs are asynchronous to the system clock. They are sampled by a two-flop synchronizer, and their falling edges are found by comparing each sample with the one before it. The data words are delayed by the same number of stages, so every edge lines up with the data that surrounded it.

Top module: `univ_bus_xcvr`

## Requirements
- R1: While `le_ab` is high, `b_out` carries the A word seen through bus-hold, bit for bit and not inverted. `b_out` always shows the stored A-to-B word, whether or not the output is enabled.
- R2: With `le_ab` already high and steady, a change on `a_in` reaches `b_out` on the third rising `clk` edge after it is applied, and not on the second.
- R3: When `le_ab` falls, the A-to-B cell keeps the A word that was present before the fall, even if A changes at the same moment.
- R4: With `le_ab` low, a falling edge on `cp_ab` stores the A word present at that edge.
- R5: With `le_ab` low and no falling edge on `cp_ab`, the stored A-to-B word does not change. Changes on A and rising edges of `cp_ab` are ignored.
- R6: `b_oe` is all ones while `oe_ab` is high and all zeros while it is low. Toggling `oe_ab` leaves the stored word on `b_out` unchanged.
- R7: The B-to-A direction behaves like A-to-B using `le_ba`, `cp_ba`, `b_in`/`b_drv` and `a_out`, except that `a_oe` is all ones while `oe_ba_n` is low and all zeros while it is high.
- R8: A bit whose `*_drv` flag is 0 is seen at the last level it had while its flag was 1 (0 after reset).
- R9: While `rst` is high, both stored words and both hold registers clear to zero, and `a_oe` and `b_oe` are zero, whatever the control inputs are.
- R10: If the latch enable and the capture clock of one direction fall together, the cell captures the pre-edge source word exactly once.

Both directions follow the same timing as R2. Control changes take effect after the same three-edge delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 18 | Level present on the A wire |
| a_drv | input | 18 | Per-bit flag: an outside driver is on the A wire |
| a_out | output | 18 | Stored B-to-A word driven toward A |
| a_oe | output | 18 | Per-bit drive enable of the A pad |
| b_in | input | 18 | Level present on the B wire |
| b_drv | input | 18 | Per-bit flag: an outside driver is on the B wire |
| b_out | output | 18 | Stored A-to-B word driven toward B |
| b_oe | output | 18 | Per-bit drive enable of the B pad |
| le_ab | input | 1 | A-to-B latch enable, high = transparent |
| cp_ab | input | 1 | A-to-B capture clock, falling edge stores |
| oe_ab | input | 1 | A-to-B output enable, active high |
| le_ba | input | 1 | B-to-A latch enable, high = transparent |
| cp_ba | input | 1 | B-to-A capture clock, falling edge stores |
| oe_ba_n | input | 1 | B-to-A output enable, active low |

## Verification
The stored word of each direction is visible on `b_out` or `a_out` at all times, independent of the enable. A wrong capture, a missed hold or a capture of the wrong edge's data therefore shows at the port three clock edges after the control change that caused it. A fault in the alignment between the control synchronizer and the data delay shows up as a post-edge word where the pre-edge word was expected, most clearly when the latch enable, the capture clock and the data all change together. A fault in the bus-hold stage shows as a bit that drops to a new value after its driver flag is cleared.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int SYNC_STAGES = 2;

  function automatic logic fell(input logic prev_s, input logic cur_s);
    return prev_s & ~cur_s;
  endfunction
endpackage

// File: rtl/xcvr_ctrl_sync.sv
module xcvr_ctrl_sync #(
  parameter int          N       = 3,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] raw,
  output logic [N-1:0] cur
);
  logic [N-1:0] meta_q;
  logic [N-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= raw;
      sync_q <= meta_q;
    end
  end

  assign cur = sync_q;
endmodule

// File: rtl/xcvr_bus_hold.sv
module xcvr_bus_hold #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_in,
  input  logic [W-1:0] pin_drv,
  output logic [W-1:0] seen
);
  logic [W-1:0] keep_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) keep_q[i] <= 1'b0;
      else if (pin_drv[i]) keep_q[i] <= pin_in[i];
    end
    assign seen[i] = pin_drv[i] ? pin_in[i] : keep_q[i];
  end

  // R8: undriven bus keeps its level
  p_float_keeps_r8: assert property (@(posedge clk) disable iff (rst)
    (pin_drv == '0) |=> ((pin_drv == '0) |-> $stable(seen)));
endmodule

// File: rtl/xcvr_dir_path.sv
module xcvr_dir_path
  import xcvr_pkg::*;
#(
  parameter int W             = 18,
  parameter bit OE_ACTIVE_LOW = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  input  logic         le_raw,
  input  logic         cp_raw,
  input  logic         oe_raw,
  output logic [W-1:0] dout,
  output logic [W-1:0] den
);
  localparam logic [2:0] CTRL_RST = {OE_ACTIVE_LOW, 1'b0, 1'b0};

  logic [2:0]   ctl_cur;
  logic         le_s, cp_s, oe_s;
  logic         le_prev, cp_prev;
  logic         le_fall, cp_fall;
  logic         oe_lvl;
  logic [W-1:0] d_meta, d_sync, d_prev;
  logic [W-1:0] word_q;
  logic         drive_q;

  xcvr_ctrl_sync #(.N(3), .RST_VAL(CTRL_RST)) u_sync (
    .clk (clk),
    .rst (rst),
    .raw ({oe_raw, cp_raw, le_raw}),
    .cur (ctl_cur)
  );

  assign le_s = ctl_cur[0];
  assign cp_s = ctl_cur[1];
  assign oe_s = ctl_cur[2];

  // data delayed by the same stages as the controls, plus one for the pre-edge copy
  always_ff @(posedge clk) begin
    if (rst) begin
      d_meta  <= '0;
      d_sync  <= '0;
      d_prev  <= '0;
      le_prev <= 1'b0;
      cp_prev <= 1'b0;
    end else begin
      d_meta  <= din;
      d_sync  <= d_meta;
      d_prev  <= d_sync;
      le_prev <= le_s;
      cp_prev <= cp_s;
    end
  end

  assign le_fall = fell(le_prev, le_s);
  assign cp_fall = fell(cp_prev, cp_s);

  always_ff @(posedge clk) begin
    if (rst)          word_q <= '0;
    else if (le_s)    word_q <= d_sync;
    else if (le_fall) word_q <= d_prev;
    else if (cp_fall) word_q <= d_sync;
  end

  if (OE_ACTIVE_LOW) begin : g_oe_low
    assign oe_lvl = ~oe_s;
  end else begin : g_oe_high
    assign oe_lvl = oe_s;
  end

  always_ff @(posedge clk) begin
    if (rst) drive_q <= 1'b0;
    else     drive_q <= oe_lvl;
  end

  assign dout = word_q;
  assign den  = {W{drive_q}};

  // R1: transparent cell follows aligned data
  p_transparent_r1: assert property (@(posedge clk) disable iff (rst)
    le_s |=> (dout == $past(d_sync)));
  // R3: latch enable fall keeps the pre-edge word
  p_le_fall_pre_r3: assert property (@(posedge clk) disable iff (rst)
    le_fall |=> (dout == $past(d_prev)));
  // R4: clock fall with latch closed stores current word
  p_cp_store_r4: assert property (@(posedge clk) disable iff (rst)
    (!le_s && !le_prev && cp_fall) |=> (dout == $past(d_sync)));
  // R5: no edge, no change
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!le_s && !le_fall && !cp_fall) |=> $stable(dout));
  // R10: simultaneous falls capture the pre-edge word
  p_dual_fall_r10: assert property (@(posedge clk) disable iff (rst)
    (le_fall && cp_fall) |=> (dout == $past(d_prev)));
  // R6: drive enable all-or-nothing
  p_den_uniform_r6: assert property (@(posedge clk) disable iff (rst)
    (den == '0) || (den == '1));
  // R9: reset clears word and enable
  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (dout == '0 && den == '0));
endmodule

// File: rtl/univ_bus_xcvr.sv
module univ_bus_xcvr #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] a_drv,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  input  logic [W-1:0] b_in,
  input  logic [W-1:0] b_drv,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe,
  input  logic         le_ab,
  input  logic         cp_ab,
  input  logic         oe_ab,
  input  logic         le_ba,
  input  logic         cp_ba,
  input  logic         oe_ba_n
);
  logic [W-1:0] a_seen, b_seen;

  xcvr_bus_hold #(.W(W)) u_hold_a (
    .clk (clk), .rst (rst), .pin_in (a_in), .pin_drv (a_drv), .seen (a_seen)
  );

  xcvr_bus_hold #(.W(W)) u_hold_b (
    .clk (clk), .rst (rst), .pin_in (b_in), .pin_drv (b_drv), .seen (b_seen)
  );

  xcvr_dir_path #(.W(W), .OE_ACTIVE_LOW(1'b0)) u_path_ab (
    .clk (clk), .rst (rst), .din (a_seen),
    .le_raw (le_ab), .cp_raw (cp_ab), .oe_raw (oe_ab),
    .dout (b_out), .den (b_oe)
  );

  xcvr_dir_path #(.W(W), .OE_ACTIVE_LOW(1'b1)) u_path_ba (
    .clk (clk), .rst (rst), .din (b_seen),
    .le_raw (le_ba), .cp_raw (cp_ba), .oe_raw (oe_ba_n),
    .dout (a_out), .den (a_oe)
  );

  // R7: B-to-A enable is active low, three edges after the input
  p_ba_polarity_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(oe_ba_n, 3) && $past(oe_ba_n, 2) && !$past(rst, 3) && !$past(rst, 2)
     && !$past(rst)) |-> (a_oe == '0));
endmodule

// File: tb/tb_univ_bus_xcvr.sv
module tb_univ_bus_xcvr;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rst;
  logic [W-1:0] a_in, a_drv, b_in, b_drv;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;
  logic le_ab, cp_ab, oe_ab, le_ba, cp_ba, oe_ba_n;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  // model state
  logic [W-1:0] m_hold_a, m_hold_b, m_st_ab, m_st_ba;
  logic m_le_ab, m_cp_ab, m_le_ba, m_cp_ba;

  always #2.5 clk = ~clk;

  univ_bus_xcvr #(.W(W)) dut (
    .clk (clk), .rst (rst),
    .a_in (a_in), .a_drv (a_drv), .a_out (a_out), .a_oe (a_oe),
    .b_in (b_in), .b_drv (b_drv), .b_out (b_out), .b_oe (b_oe),
    .le_ab (le_ab), .cp_ab (cp_ab), .oe_ab (oe_ab),
    .le_ba (le_ba), .cp_ba (cp_ba), .oe_ba_n (oe_ba_n)
  );

  function automatic logic [W-1:0] held(input logic [W-1:0] old_h, input logic [W-1:0] v,
                                        input logic [W-1:0] drv);
    return (old_h & ~drv) | (v & drv);
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // inputs were just driven at a negedge; advance model, settle, check
  task automatic settle_check(input string tag_ab);
    logic [W-1:0] nh_a, nh_b;
    string t;
    nh_a = held(m_hold_a, a_in, a_drv);
    nh_b = held(m_hold_b, b_in, b_drv);
    t = "R5";
    if (le_ab) begin m_st_ab = nh_a; t = "R1"; end
    else if (m_le_ab) begin m_st_ab = m_hold_a; t = "R3"; end
    else if (m_cp_ab && !cp_ab) begin m_st_ab = nh_a; t = "R4"; end
    if (le_ba) m_st_ba = nh_b;
    else if (m_le_ba) m_st_ba = m_hold_b;
    else if (m_cp_ba && !cp_ba) m_st_ba = nh_b;
    m_hold_a = nh_a; m_hold_b = nh_b;
    m_le_ab = le_ab; m_cp_ab = cp_ab; m_le_ba = le_ba; m_cp_ba = cp_ba;
    repeat (5) @(negedge clk);
    if (tag_ab != "") t = tag_ab;
    chk(t, b_out, m_st_ab);
    chk("R6", b_oe, {W{oe_ab}});
    chk("R7 data", a_out, m_st_ba);
    chk("R7 enable", a_oe, {W{~oe_ba_n}});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] x1, x2, x3;
    void'($urandom(32'd20240611));
    // R9: reset with every enable asserted
    rst = 1'b1;
    a_in = 18'h2A5C3; a_drv = '1; b_in = 18'h15A3C; b_drv = '1;
    le_ab = 1'b1; cp_ab = 1'b0; oe_ab = 1'b1;
    le_ba = 1'b1; cp_ba = 1'b0; oe_ba_n = 1'b0;
    repeat (6) @(negedge clk);
    chk("R9 b_out", b_out, '0);
    chk("R9 b_oe", b_oe, '0);
    chk("R9 a_out", a_out, '0);
    chk("R9 a_oe", a_oe, '0);
    m_hold_a = '0; m_hold_b = '0; m_st_ab = '0; m_st_ba = '0;
    m_le_ab = 1'b0; m_cp_ab = 1'b0; m_le_ba = 1'b0; m_cp_ba = 1'b0;
    rst = 1'b0;
    settle_check("R1");

    // R2: latency of a transparent data change
    x1 = b_out; x2 = ~x1;
    a_in = x2;
    repeat (2) @(negedge clk);
    chk("R2 two edges", b_out, x1);
    @(negedge clk);
    chk("R2 three edges", b_out, x2);
    settle_check("R1");

    // R10: latch enable, clock and data all change together
    cp_ab = 1'b1; x1 = 18'h0F0F0; a_in = x1;
    settle_check("R1");
    le_ab = 1'b0; cp_ab = 1'b0; a_in = 18'h3C3C3;
    settle_check("R10");
    chk("R10 pre-edge word", b_out, x1);

    // R5: latch closed, A and rising clock ignored
    x3 = 18'h12345; a_in = x3;
    settle_check("R5");
    cp_ab = 1'b1;
    settle_check("R5");
    chk("R5 still old", b_out, x1);
    // R4: falling clock stores current A
    cp_ab = 1'b0;
    settle_check("R4");
    chk("R4 stored", b_out, x3);

    // R6: toggling the enable keeps the word
    oe_ab = 1'b0;
    settle_check("R6");
    chk("R6 word kept", b_out, x3);
    oe_ab = 1'b1;
    settle_check("R6");

    // R8: bus hold on A with transparent path
    le_ab = 1'b1; a_in = 18'h3FF00; a_drv = '1;
    settle_check("R1");
    a_drv = '0;
    settle_check("R8");
    a_in = 18'h000FF;
    settle_check("R8");
    chk("R8 floating keeps", b_out, 18'h3FF00);
    a_drv = 18'h001FF;
    settle_check("R8");
    chk("R8 partial drive", b_out, 18'h3FEFF);

    // R3: plain latch-enable fall with simultaneous A change
    x1 = 18'h2AAAA; a_in = x1; a_drv = '1;
    settle_check("R1");
    le_ab = 1'b0; a_in = 18'h15555;
    settle_check("R3");
    chk("R3 pre-edge", b_out, x1);

    // R7: B-to-A direction directed
    le_ba = 1'b0; cp_ba = 1'b1; b_in = 18'h0BEEF; b_drv = '1;
    settle_check("");
    cp_ba = 1'b0; oe_ba_n = 1'b1;
    settle_check("");
    chk("R7 stored", a_out, 18'h0BEEF);

    // random single and mixed changes
    for (int i = 0; i < 400; i++) begin
      int k;
      k = $urandom_range(0, 11);
      case (k)
        0: a_in = W'($urandom);
        1: a_drv = ($urandom_range(0, 3) == 0) ? W'($urandom) : '1;
        2: b_in = W'($urandom);
        3: b_drv = ($urandom_range(0, 3) == 0) ? W'($urandom) : '1;
        4: le_ab = ~le_ab;
        5: cp_ab = ~cp_ab;
        6: oe_ab = ~oe_ab;
        7: le_ba = ~le_ba;
        8: cp_ba = ~cp_ba;
        9: oe_ba_n = ~oe_ba_n;
        10: begin le_ab = ~le_ab; a_in = W'($urandom); end
        default: begin cp_ba = ~cp_ba; le_ba = ~le_ba; b_in = W'($urandom); end
      endcase
      settle_check("");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule